// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block sits between a core's load/store port and an external asynchronous memory bus. It accepts one read or write request at a time and plays it out on the bus as a series of single-clock phases. An address phase comes first. Optional wait phases follow, then a data phase, an optional write tail, optional hold phases and, where needed, an idle gap before the next access. The configuration for the zone being accessed arrives as plain inputs. The block captures it when a request is accepted, so each access uses one consistent setting.

On an 8-bit bus a word access is split into two byte accesses, low byte first at the lower address. A word read may instead use a burst, where a second data phase follows the first without a new address phase. A one-phase fast read is also supported. Idle gaps are inserted automatically between access types that could otherwise fight over the data lines.

The core holds `req_valid` and the request fields steady until it sees `core_done`. The block samples a new request only while it is waiting for work, which happens once all hold phases of the previous access are over. `core_rdata` is valid in the cycle that `core_done` is high. All bus controls are active high.

Top module: `ext_bus_sequencer`

## Requirements
- R1: Every bus access begins with one address phase in which `bus_sel` is high, `bus_addr` shows the access address, and neither `bus_oe` nor any bit of `bus_wr` is high.
- R2: A non-fast access has exactly `cfg_wait` wait phases between the address phase and the data phase, with `bus_sel` held high. During these phases a write drives `bus_oe`.
- R3: A normal read ends in the data phase, which comes 2+`cfg_wait` cycles after acceptance. `core_done` is high in that phase. On a 16-bit bus `core_rdata` equals `bus_din`. A byte read on an 8-bit bus returns {8'h00, `bus_din[7:0]`}.
- R4: When `cfg_fast_rd` is set, a read uses one phase in which `bus_sel`, `bus_rd` and `core_done` are all high, and `cfg_wait` is ignored.
- R5: For a late write (`cfg_early_wr`=0), `bus_wr` is high only in the data phase, and `core_done` is high in that phase. An early write keeps `bus_wr` high from the first wait or data phase through one extra tail phase. In that tail phase `bus_sel` is low, `core_done` is high, and `bus_oe`, `bus_addr` and `bus_dout` are unchanged. A write strobe is never high without `bus_oe`.
- R6: A word read on an 8-bit bus with `cfg_burst_en` set uses a single address phase and a second data phase, with select and read held high throughout. `bus_addr` advances by one either at an extra burst-wait phase (when `cfg_burst_wait` is set) or at the second data phase. `core_done` comes in the second data phase with {second byte, first byte}.
- R7: Without burst, a word read on an 8-bit bus becomes two complete accesses, and a word write on an 8-bit bus always does. The first access is at the request address, the second at address+1 carrying the high byte. `core_done` fires only in the second access.
- R8: After each access's final data or tail phase there are exactly `cfg_hold` hold phases. In them `bus_sel`, `bus_rd` and `bus_wr` are low, `bus_addr` is kept, and a write keeps `bus_oe` and `bus_dout` steady. `bus_oe` drops after the last hold phase. `bus_oe` is never high while `bus_rd` is high.
- R9: One idle phase is inserted before the address phase of a read that follows an early write, and before a fast read that follows a late write. No idle phase is inserted before a normal read that follows a late write.
- R10: `cfg_pre_idle` on a request inserts one idle phase before it. `cfg_post_idle` on a request inserts one idle phase before the next request. When both apply, or when they coincide with a rule from R9, only one idle phase is inserted. The previous access's idle demands are cleared by any cycle in which the block is waiting with no request.
- R11: On an 8-bit bus only `bus_wr[0]` is used and the byte is on `bus_dout[7:0]`. On a 16-bit bus `bus_wr[0]` follows `req_be[0]` for `bus_dout[7:0]` and `bus_wr[1]` follows `req_be[1]` for `bus_dout[15:8]`.
- R12: After reset `bus_sel`, `bus_rd`, `bus_wr`, `bus_oe` and `core_done` are low. `core_done` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present, held until `core_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 16 | Write data, low byte at the lower address |
| req_be | input | 2 | Byte lane enables for 16-bit bus writes |
| core_rdata | output | 16 | Read result, valid with `core_done` |
| core_done | output | 1 | One-cycle completion pulse |
| cfg_wait | input | WAITW | Number of wait phases |
| cfg_hold | input | HOLDW | Number of hold phases |
| cfg_burst_en | input | 1 | Allow burst word reads on an 8-bit bus |
| cfg_burst_wait | input | 1 | Add one burst-wait phase before the second data phase |
| cfg_bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_early_wr | input | 1 | 1 = early write with tail phase, 0 = late write |
| cfg_fast_rd | input | 1 | Single-phase reads |
| cfg_pre_idle | input | 1 | Idle phase before this access |
| cfg_post_idle | input | 1 | Idle phase before the next access |
| bus_addr | output | AW | Bus address |
| bus_dout | output | 16 | Bus write data |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | 16 | Bus read data |
| bus_sel | output | 1 | Device select |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 2 | Byte write strobes |

## Verification
Most faults in the phase state or its counters show up as a `core_done` pulse in the wrong cycle. The bench predicts that cycle exactly for every access, so an extra or missing wait, hold, tail or idle phase is caught as soon as that access completes. A wrong half-select or byte register gives a misplaced byte in `core_rdata`, or a byte written to the wrong location, which the next read-back exposes. Faults in the strobe and drive-enable decoding appear in the same cycle through the per-phase port log, the strobe-with-data watch, and the hold-stability assertions.

// File: rtl/ext_bus_sequencer.sv
module ext_bus_sequencer #(
  parameter int AW    = 16,
  parameter int WAITW = 3,
  parameter int HOLDW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_word,
  input  logic [AW-1:0]    req_addr,
  input  logic [15:0]      req_wdata,
  input  logic [1:0]       req_be,
  output logic [15:0]      core_rdata,
  output logic             core_done,
  input  logic [WAITW-1:0] cfg_wait,
  input  logic [HOLDW-1:0] cfg_hold,
  input  logic             cfg_burst_en,
  input  logic             cfg_burst_wait,
  input  logic             cfg_bus16,
  input  logic             cfg_early_wr,
  input  logic             cfg_fast_rd,
  input  logic             cfg_pre_idle,
  input  logic             cfg_post_idle,
  output logic [AW-1:0]    bus_addr,
  output logic [15:0]      bus_dout,
  output logic             bus_oe,
  input  logic [15:0]      bus_din,
  output logic             bus_sel,
  output logic             bus_rd,
  output logic [1:0]       bus_wr
);

  localparam int CW = (WAITW > HOLDW) ? WAITW : HOLDW;

  typedef enum logic [3:0] {
    S_READY, S_GAP, S_T1, S_TIW, S_T2, S_TF, S_TBW, S_T2B, S_T3, S_HOLD
  } phase_t;

  phase_t st;
  logic             q_write, q_word, q_burst_en, q_bw, q_bus16, q_early, q_fast;
  logic [1:0]       q_be;
  logic [15:0]      q_wdata;
  logic [WAITW-1:0] q_wait;
  logic [HOLDW-1:0] q_hold;
  logic [AW-1:0]    addr_r;
  logic [CW-1:0]    cnt;
  logic             half;
  logic [7:0]       lo_byte;
  logic             prev_post, prev_ew, prev_lw;

  wire narrow_word = q_word & ~q_bus16;
  wire burst       = narrow_word & ~q_write & q_burst_en;
  wire split       = narrow_word & ~burst;
  wire last_sub    = ~split | half;
  wire fast        = q_fast & ~q_write;

  wire need_gap = cfg_pre_idle | prev_post | (prev_ew & ~req_write) |
                  (prev_lw & ~req_write & cfg_fast_rd);

  wire data_end = (st == S_T3) || (st == S_T2B) ||
                  ((st == S_T2 || st == S_TF) && !burst && !(q_write && q_early));
  wire sub_end  = (data_end && q_hold == '0) || (st == S_HOLD && cnt == '0);
  wire lo_cap   = (st == S_T2 || st == S_TF) && !q_write && narrow_word && !half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_READY;
      q_write <= 1'b0; q_word <= 1'b0; q_burst_en <= 1'b0; q_bw <= 1'b0;
      q_bus16 <= 1'b0; q_early <= 1'b0; q_fast <= 1'b0;
      q_be <= '0; q_wdata <= '0; q_wait <= '0; q_hold <= '0;
      addr_r <= '0; cnt <= '0; half <= 1'b0; lo_byte <= '0;
      prev_post <= 1'b0; prev_ew <= 1'b0; prev_lw <= 1'b0;
    end else begin
      if (lo_cap) lo_byte <= bus_din[7:0];
      case (st)
        S_READY: begin
          if (req_valid) begin
            q_write <= req_write; q_word <= req_word; q_be <= req_be;
            q_wdata <= req_wdata; q_wait <= cfg_wait; q_hold <= cfg_hold;
            q_burst_en <= cfg_burst_en; q_bw <= cfg_burst_wait;
            q_bus16 <= cfg_bus16; q_early <= cfg_early_wr; q_fast <= cfg_fast_rd;
            addr_r <= req_addr;
            half <= 1'b0;
            prev_post <= cfg_post_idle;
            prev_ew <= req_write & cfg_early_wr;
            prev_lw <= req_write & ~cfg_early_wr;
            st <= need_gap ? S_GAP : ((cfg_fast_rd && !req_write) ? S_TF : S_T1);
          end else begin
            prev_post <= 1'b0;
            prev_ew <= 1'b0;
            prev_lw <= 1'b0;
          end
        end
        S_GAP: st <= fast ? S_TF : S_T1;
        S_T1: begin
          if (q_wait != '0) begin
            st <= S_TIW;
            cnt <= CW'(q_wait) - CW'(1);
          end else begin
            st <= S_T2;
          end
        end
        S_TIW: begin
          if (cnt == '0) st <= S_T2;
          else cnt <= cnt - CW'(1);
        end
        S_T2, S_TF: begin
          if (burst) begin
            st <= q_bw ? S_TBW : S_T2B;
            addr_r <= addr_r + AW'(1);
          end else if (st == S_T2 && q_write && q_early) begin
            st <= S_T3;
          end
        end
        S_TBW: st <= S_T2B;
        S_HOLD: if (cnt != '0) cnt <= cnt - CW'(1);
        default: ;
      endcase
      if (data_end && q_hold != '0) begin
        st <= S_HOLD;
        cnt <= CW'(q_hold) - CW'(1);
      end
      if (sub_end) begin
        if (!last_sub) begin
          half <= 1'b1;
          addr_r <= addr_r + AW'(1);
          st <= fast ? S_TF : S_T1;
        end else begin
          st <= S_READY;
        end
      end
    end
  end

  wire sel_on = (st == S_T1) || (st == S_TIW) || (st == S_T2) || (st == S_TF) ||
                (st == S_TBW) || (st == S_T2B);
  wire wr_on  = q_write && (q_early ? (st == S_TIW || st == S_T2 || st == S_T3)
                                    : (st == S_T2));

  assign bus_sel  = sel_on;
  assign bus_rd   = sel_on & ~q_write;
  assign bus_wr   = wr_on ? (q_bus16 ? q_be : 2'b01) : 2'b00;
  assign bus_oe   = q_write && (st == S_TIW || st == S_T2 || st == S_T3 || st == S_HOLD);
  assign bus_addr = addr_r;
  assign bus_dout = q_bus16 ? q_wdata : {8'h00, (half ? q_wdata[15:8] : q_wdata[7:0])};

  assign core_done  = data_end & last_sub;
  assign core_rdata = !core_done ? 16'h0000 :
                      q_bus16    ? bus_din :
                      q_word     ? {bus_din[7:0], lo_byte} : {8'h00, bus_din[7:0]};

  // R1
  t1_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_sel) |-> (!bus_oe && bus_wr == 2'b00));

  // R5
  strobe_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr != 2'b00) |-> bus_oe);

  // R8
  write_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> ($stable(bus_addr) && $stable(bus_dout)));

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_oe));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);

endmodule

// File: tb/ext_bus_sequencer_test.sv
`timescale 1ns/1ps
module ext_bus_sequencer_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] core_rdata;
  logic        core_done;
  logic [2:0]  cfg_wait = '0;
  logic [1:0]  cfg_hold = '0;
  logic cfg_burst_en = 0, cfg_burst_wait = 0, cfg_bus16 = 0, cfg_early_wr = 0;
  logic cfg_fast_rd = 0, cfg_pre_idle = 0, cfg_post_idle = 0;
  logic [15:0] bus_addr, bus_dout, bus_din;
  logic        bus_oe, bus_sel, bus_rd;
  logic [1:0]  bus_wr;

  ext_bus_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .core_rdata(core_rdata), .core_done(core_done), .cfg_wait(cfg_wait),
    .cfg_hold(cfg_hold), .cfg_burst_en(cfg_burst_en), .cfg_burst_wait(cfg_burst_wait),
    .cfg_bus16(cfg_bus16), .cfg_early_wr(cfg_early_wr), .cfg_fast_rd(cfg_fast_rd),
    .cfg_pre_idle(cfg_pre_idle), .cfg_post_idle(cfg_post_idle), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .bus_sel(bus_sel),
    .bus_rd(bus_rd), .bus_wr(bus_wr)
  );

  logic [7:0] mem [0:255];
  wire  [7:0] ba = bus_addr[7:0];
  assign bus_din = cfg_bus16 ? {mem[{ba[7:1], 1'b1}], mem[{ba[7:1], 1'b0}]}
                             : {8'hEE, mem[ba]};

  int n_chk = 0, n_fail = 0, cyc = 0, t0 = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic       lsel [0:511], lrd [0:511], loe [0:511], ldone [0:511];
  logic [1:0] lwr  [0:511];
  logic [7:0] laddr[0:511];

  int          q_cyc[$];
  logic [15:0] q_dat[$];
  logic        q_isrd[$];
  string       q_req[$];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // monitor: port log, write capture, scoreboard on completion
  always @(negedge clk) begin
    lsel[cyc % 512] = bus_sel;  lrd[cyc % 512] = bus_rd;  loe[cyc % 512] = bus_oe;
    ldone[cyc % 512] = core_done; lwr[cyc % 512] = bus_wr; laddr[cyc % 512] = ba;
    if (rst_n && bus_wr != 2'b00) begin
      chk("R5 strobe without data drive", bus_oe, 1);
      if (!cfg_bus16) begin
        chk("R11 8-bit bus strobe lane", bus_wr, 2'b01);
        mem[ba] = bus_dout[7:0];
      end else begin
        if (bus_wr[0]) mem[{ba[7:1], 1'b0}] = bus_dout[7:0];
        if (bus_wr[1]) mem[{ba[7:1], 1'b1}] = bus_dout[15:8];
      end
    end
    if (rst_n && core_done) begin
      if (q_cyc.size() == 0) begin
        chk("R12 unexpected done", 1, 0);
      end else begin
        automatic int          ec = q_cyc.pop_front();
        automatic logic [15:0] ed = q_dat.pop_front();
        automatic logic        er = q_isrd.pop_front();
        automatic string       rq = q_req.pop_front();
        chk({rq, " done cycle"}, cyc - t0, ec - t0);
        if (er) chk({rq, " read data"}, core_rdata, ed);
      end
    end
  end

  task automatic do_txn(input logic wr, input logic word, input logic [7:0] a,
                        input logic [15:0] wd, input logic [1:0] be, input int len,
                        input logic [15:0] exp_rd, input string r);
    int n;
    req_write = wr; req_word = word; req_addr = {8'h00, a};
    req_wdata = wd; req_be = be; req_valid = 1'b1;
    t0 = cyc;
    q_cyc.push_back(t0 + len); q_dat.push_back(exp_rd);
    q_isrd.push_back(!wr); q_req.push_back(r);
    n = 0;
    @(negedge clk);
    while (!core_done && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (n >= 200) chk({r, " no completion"}, 0, 1);
    req_valid = 1'b0;
    repeat (int'(cfg_hold) + 1) @(negedge clk);
  endtask

  function automatic int ix(input int k);
    return (t0 + k) % 512;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] old40;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (4) @(negedge clk);
    chk("R12 reset sel", bus_sel, 0);
    chk("R12 reset rd", bus_rd, 0);
    chk("R12 reset wr", bus_wr, 0);
    chk("R12 reset oe", bus_oe, 0);
    chk("R12 reset done", core_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R8: byte read, two waits, one hold
    cfg_wait = 3'd2; cfg_hold = 2'd1;
    do_txn(0, 0, 8'h10, 0, 0, 4, {8'h00, mem[8'h10]}, "R3 byte read 8-bit");
    chk("R1 address phase select", lsel[ix(1)], 1);
    chk("R1 address phase address", laddr[ix(1)], 8'h10);
    chk("R2 select held in wait", lsel[ix(3)], 1);
    chk("R8 select low in hold", lsel[ix(5)], 0);
    chk("R8 address held in hold", laddr[ix(5)], 8'h10);
    chk("R12 done single cycle", ldone[ix(5)], 0);

    // R3: word read on 16-bit bus
    cfg_wait = 0; cfg_hold = 0; cfg_bus16 = 1;
    do_txn(0, 1, 8'h20, 0, 0, 2, {mem[8'h21], mem[8'h20]}, "R3 word read 16-bit");

    // R4: fast read ignores waits
    cfg_bus16 = 0; cfg_fast_rd = 1; cfg_wait = 3'd3;
    do_txn(0, 0, 8'h31, 0, 0, 1, {8'h00, mem[8'h31]}, "R4 fast read");
    chk("R4 read strobe in single phase", lrd[ix(1)], 1);
    chk("R4 select gone next cycle", lsel[ix(2)], 0);
    cfg_fast_rd = 0;

    // R11 R2 R5: late write high lane on 16-bit bus
    cfg_bus16 = 1; cfg_wait = 3'd1;
    old40 = mem[8'h40];
    do_txn(1, 1, 8'h40, 16'hA55A, 2'b10, 3, 0, "R5 late write 16-bit");
    chk("R1 no drive in address phase", loe[ix(1)], 0);
    chk("R2 data driven in wait", loe[ix(2)], 1);
    chk("R5 late strobe not in wait", lwr[ix(2)], 0);
    chk("R11 odd lane strobe", lwr[ix(3)], 2'b10);
    cfg_wait = 0;
    do_txn(0, 1, 8'h40, 0, 0, 2, {8'hA5, old40}, "R9 read after late write no gap");

    // R5 R8: early write with wait and hold, then read needs gap (R9)
    cfg_bus16 = 0; cfg_early_wr = 1; cfg_wait = 3'd1; cfg_hold = 2'd1;
    do_txn(1, 0, 8'h50, 16'h003C, 0, 4, 0, "R5 early write");
    chk("R5 early strobe from wait", lwr[ix(2)], 2'b01);
    chk("R5 tail select low", lsel[ix(4)], 0);
    chk("R5 tail strobe high", lwr[ix(4)], 2'b01);
    chk("R5 tail data drive", loe[ix(4)], 1);
    chk("R8 hold strobe low", lwr[ix(5)], 0);
    chk("R8 hold data drive", loe[ix(5)], 1);
    chk("R8 drive released", loe[ix(6)], 0);
    cfg_wait = 0; cfg_hold = 0;
    do_txn(0, 0, 8'h50, 0, 0, 3, 16'h003C, "R9 read after early write");
    chk("R9 idle phase select low", lsel[ix(1)], 0);

    // R9: late write then fast read gets gap
    cfg_early_wr = 0;
    do_txn(1, 0, 8'h60, 16'h0077, 0, 2, 0, "R5 late write 8-bit");
    cfg_fast_rd = 1;
    do_txn(0, 0, 8'h60, 0, 0, 2, 16'h0077, "R9 fast read after late write");
    cfg_fast_rd = 0;

    // R6: burst without burst-wait
    cfg_burst_en = 1; cfg_wait = 3'd1;
    do_txn(0, 1, 8'h70, 0, 0, 4, {mem[8'h71], mem[8'h70]}, "R6 burst read");
    chk("R6 first byte address", laddr[ix(3)], 8'h70);
    chk("R6 address advanced", laddr[ix(4)], 8'h71);
    chk("R6 select held", lsel[ix(4)], 1);

    // R6: burst with burst-wait
    cfg_burst_wait = 1; cfg_wait = 0;
    do_txn(0, 1, 8'h80, 0, 0, 4, {mem[8'h81], mem[8'h80]}, "R6 burst read with wait");
    chk("R6 address before burst wait", laddr[ix(2)], 8'h80);
    chk("R6 address advanced at burst wait", laddr[ix(3)], 8'h81);
    chk("R6 no done in burst wait", ldone[ix(3)], 0);
    cfg_burst_wait = 0;

    // R7: split read with hold
    cfg_burst_en = 0; cfg_hold = 2'd1;
    do_txn(0, 1, 8'h90, 0, 0, 5, {mem[8'h91], mem[8'h90]}, "R7 split read");
    chk("R7 no done in first access", ldone[ix(2)], 0);
    chk("R7 hold between accesses", lsel[ix(3)], 0);
    chk("R7 second access address", laddr[ix(4)], 8'h91);

    // R7 R11: split write, read back on 16-bit bus
    cfg_hold = 0;
    do_txn(1, 1, 8'hA0, 16'h1234, 2'b11, 4, 0, "R7 split write");
    chk("R11 first byte lane", lwr[ix(2)], 2'b01);
    chk("R7 second byte address", laddr[ix(4)], 8'hA1);
    cfg_bus16 = 1;
    do_txn(0, 1, 8'hA0, 0, 0, 2, 16'h1234, "R7 split write read-back");
    cfg_bus16 = 0;

    // R10: pre and post idle merge
    cfg_pre_idle = 1;
    do_txn(0, 0, 8'hB0, 0, 0, 3, {8'h00, mem[8'hB0]}, "R10 pre idle");
    cfg_pre_idle = 0; cfg_post_idle = 1;
    do_txn(0, 0, 8'hB1, 0, 0, 2, {8'h00, mem[8'hB1]}, "R10 post idle request");
    cfg_post_idle = 0; cfg_pre_idle = 1;
    do_txn(0, 0, 8'hB2, 0, 0, 3, {8'h00, mem[8'hB2]}, "R10 merged idle");
    cfg_pre_idle = 0;
    do_txn(0, 0, 8'hB3, 0, 0, 2, {8'h00, mem[8'hB3]}, "R10 no idle");
    cfg_post_idle = 1;
    do_txn(0, 0, 8'hB4, 0, 0, 2, {8'h00, mem[8'hB4]}, "R10 post idle set");
    cfg_post_idle = 0;
    do_txn(0, 0, 8'hB5, 0, 0, 3, {8'h00, mem[8'hB5]}, "R10 post idle alone");

    repeat (3) @(negedge clk);
    chk("R12 all completions seen", q_cyc.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule